// File: doc/BRIEF.md
# Host-Watchdog Mode Supervisor

This block decides whether a charger-style controller is steered by a host processor or runs on its own. It holds a small bank of byte-wide registers that are reached through a plain write/read port. It also runs a watchdog counter whose timeout length the host programs. A register write from the host puts the block into host mode and starts the watchdog. If the host then stops servicing the watchdog, the block falls back to autonomous (default) mode and reloads its registers with their defaults.

The host keeps control in one of two ways. It can set the self-clearing restart bit before the count runs out, or it can program the period field to zero, which switches the watchdog off. A status register reports the current mode. The same register holds a sticky event flag that clears when it is read. Each timeout also drives an active-low interrupt pulse, which a mask bit can suppress. The output `charge_dflt_o` is high whenever the block is in autonomous mode, which tells the charging logic it may proceed on its default profile.

Register map (8-bit data):
- address 0, control: bits [1:0] period code, bit 2 restart, bit 3 interrupt mask
- address 1, config A: default 0x5A
- address 2, config B: default 0xC3
- address 3, retained scratch: default 0x00
- address 4, status (read only): bit 0 mode, bit 1 event flag
- unused addresses read as 0

Top module: `wds_mode_sup`

## Requirements
- R1: After reset the block is in default mode: `charge_dflt_o`=1 and `int_n_o`=1. The register values are control=0x01, config A=0x5A, config B=0xC3 and scratch=0x00.
- R2: Status bit 0 (address 4) reads 1 in default mode and 0 in host mode. Read data appears on `rd_data` one cycle after `rd_en`.
- R3: Any write made in default mode switches the block to host mode on the next cycle and clears the count. With period code 01, 10 or 11 the block stays in host mode for exactly T1, T2 or T3 cycles after that write unless the host restarts the count.
- R4: On timeout the block returns to default mode and reloads control, config A and config B to their defaults. A write that is not a restart and that lands in the timeout cycle is discarded.
- R5: The scratch register at address 3 keeps its value through a timeout.
- R6: In host mode, writing control with bit 2 set restarts the count, and this holds even in the timeout cycle. Bit 2 always reads back as 0.
- R7: The event flag (status bit 1) is set by reset and by every timeout, and it is cleared by a read of address 4. When a read and a timeout fall in the same cycle, the set wins and the read returns the old value.
- R8: A timeout drives `int_n_o` low for IRQ_LEN cycles starting with the cycle after the timeout, unless control bit 3 is 1. The mask does not stop the flag from being set.
- R9: Period code 00 disables the watchdog, so host mode is held for as long as the code stays 00.
- R10: Writes to the status address change no status bit, but they still count as a write for mode entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Registered read data |
| charge_dflt_o | output | 1 | High in autonomous (default) mode |
| int_n_o | output | 1 | Active-low timeout interrupt pulse |

## Verification
Two pairs of functions can collide in the timeout cycle. The first pair is timeout and restart. The bench waits until the count sits at its last value and then writes the restart bit on that edge. The expected result is that host mode is held and the full period runs again. The second pair is timeout and a clear-on-read of the status register. The bench reads the status on the timeout edge and expects the pre-event value, and the next read must show the flag set again. A non-restart write on the timeout edge is also checked: its data must be lost to the reload.

// File: rtl/wds_pkg.sv
package wds_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_CFGA = 3'd1;
    localparam logic [ADDR_W-1:0] A_CFGB = 3'd2;
    localparam logic [ADDR_W-1:0] A_KEEP = 3'd3;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd4;

    localparam int B_KICK = 2;
    localparam int B_MASK = 3;

    localparam logic [DATA_W-1:0] D_CTRL = 8'h01;
    localparam logic [DATA_W-1:0] D_CFGA = 8'h5A;
    localparam logic [DATA_W-1:0] D_CFGB = 8'hC3;
    localparam logic [DATA_W-1:0] D_KEEP = 8'h00;

    typedef logic [1:0] period_t;

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] cfga;
        logic [DATA_W-1:0] cfgb;
        logic [DATA_W-1:0] keep;
        logic              flag;
        logic [DATA_W-1:0] rdata;
    } bank_t;
endpackage

// File: rtl/wds_timer.sv
module wds_timer #(
    parameter int T1 = 64,
    parameter int T2 = 256,
    parameter int T3 = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  wds_pkg::period_t period,
    output logic             expire
);
    localparam int CW = $clog2(T3 + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tm_t;

    tm_t           s_d, s_q;
    logic [CW-1:0] lim;

    always_comb begin
        case (period)
            2'b01:   lim = CW'(T1 - 1);
            2'b10:   lim = CW'(T2 - 1);
            2'b11:   lim = CW'(T3 - 1);
            default: lim = '0;
        endcase
        // a shortened period takes effect at once through >=
        expire = run && !restart && (s_q.cnt >= lim);
        s_d = s_q;
        if (!run || restart || expire) s_d.cnt = '0;
        else                           s_d.cnt = s_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/wds_irq.sv
module wds_irq #(
    parameter int IRQ_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic mask,
    output logic int_n
);
    localparam int LW = $clog2(IRQ_LEN + 1);

    typedef struct packed {
        logic [LW-1:0] left;
    } irq_t;

    irq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (fire && !mask)       s_d.left = LW'(IRQ_LEN);
        else if (s_q.left != '0) s_d.left = s_q.left - 1'b1;
        int_n = (s_q.left == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/wds_regbank.sv
module wds_regbank
    import wds_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              reload,
    input  logic              set_flag,
    input  logic              stat_dflt,
    output logic [DATA_W-1:0] rd_data,
    output period_t           period,
    output logic              mask
);
    bank_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (rd_en) begin
            case (rd_addr)
                A_CTRL:  s_d.rdata = s_q.ctrl;
                A_CFGA:  s_d.rdata = s_q.cfga;
                A_CFGB:  s_d.rdata = s_q.cfgb;
                A_KEEP:  s_d.rdata = s_q.keep;
                A_STAT: begin
                    s_d.rdata = {{(DATA_W-2){1'b0}}, s_q.flag, stat_dflt};
                    s_d.flag  = 1'b0;
                end
                default: s_d.rdata = '0;
            endcase
        end
        if (reload) begin
            s_d.ctrl = D_CTRL;
            s_d.cfga = D_CFGA;
            s_d.cfgb = D_CFGB;
        end else if (wr_en) begin
            case (wr_addr)
                A_CTRL: begin
                    s_d.ctrl         = wr_data;
                    s_d.ctrl[B_KICK] = 1'b0;
                end
                A_CFGA:  s_d.cfga = wr_data;
                A_CFGB:  s_d.cfgb = wr_data;
                A_KEEP:  s_d.keep = wr_data;
                default: ;
            endcase
        end
        if (set_flag) s_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.ctrl  <= D_CTRL;
            s_q.cfga  <= D_CFGA;
            s_q.cfgb  <= D_CFGB;
            s_q.keep  <= D_KEEP;
            s_q.flag  <= 1'b1;
            s_q.rdata <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_data = s_q.rdata;
    assign period  = s_q.ctrl[1:0];
    assign mask    = s_q.ctrl[B_MASK];
endmodule

// File: rtl/wds_mode_sup.sv
module wds_mode_sup #(
    parameter int T1      = 64,
    parameter int T2      = 256,
    parameter int T3      = 1024,
    parameter int IRQ_LEN = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       rd_en,
    input  logic [2:0] rd_addr,
    output logic [7:0] rd_data,
    output logic       charge_dflt_o,
    output logic       int_n_o
);
    import wds_pkg::*;

    typedef struct packed {
        logic host;
    } mode_t;

    mode_t   m_d, m_q;
    period_t period_q;
    logic    mask_q;
    logic    enter, kick, expire, run;

    always_comb begin
        enter = !m_q.host && wr_en;
        kick  = m_q.host && wr_en && (wr_addr == A_CTRL) && wr_data[B_KICK];
        run   = m_q.host && (period_q != 2'b00);
        m_d   = m_q;
        if (expire)     m_d.host = 1'b0;
        else if (enter) m_d.host = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    wds_timer #(.T1(T1), .T2(T2), .T3(T3)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (enter || kick),
        .period  (period_q),
        .expire  (expire)
    );

    wds_regbank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en && !expire),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .reload    (expire),
        .set_flag  (expire),
        .stat_dflt (!m_q.host),
        .rd_data   (rd_data),
        .period    (period_q),
        .mask      (mask_q)
    );

    wds_irq #(.IRQ_LEN(IRQ_LEN)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (expire),
        .mask  (mask_q),
        .int_n (int_n_o)
    );

    assign charge_dflt_o = !m_q.host;
endmodule

// File: rtl/wds_checker.sv
module wds_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [2:0] wr_addr,
    input logic [7:0] wr_data,
    input logic       charge_dflt_o,
    input logic       int_n_o,
    input logic [1:0] period_q,
    input logic       mask_q
);
    p_host_needs_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(charge_dflt_o) |-> $past(wr_en));

    p_kick_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!charge_dflt_o && wr_en && wr_addr == 3'd0 && wr_data[2]) |=> !charge_dflt_o);

    p_disabled_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!charge_dflt_o && period_q == 2'b00) |=> !charge_dflt_o);

    p_irq_after_expiry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(int_n_o) |-> $rose(charge_dflt_o));

    p_unmasked_fires_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(charge_dflt_o) && !$past(mask_q)) |-> !int_n_o);
endmodule

bind wds_mode_sup wds_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .charge_dflt_o (charge_dflt_o),
    .int_n_o       (int_n_o),
    .period_q      (period_q),
    .mask_q        (mask_q)
);

// File: tb/tb_wds_mode_sup.sv
`timescale 1ns/1ps
module tb_wds_mode_sup;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0] wr_addr = '0, rd_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       charge_dflt_o, int_n_o;
    int         n_chk = 0, n_bad = 0;
    logic [7:0] r;

    always #10 clk = ~clk;

    wds_mode_sup #(.T1(8), .T2(16), .T3(32), .IRQ_LEN(3)) dut (.*);

    // {is_read, addr, data, expected}
    localparam logic [19:0] VEC [11] = '{
        {1'b0, 3'd0, 8'h03, 8'h00},
        {1'b0, 3'd1, 8'hA5, 8'h00},
        {1'b0, 3'd2, 8'h3C, 8'h00},
        {1'b0, 3'd3, 8'h77, 8'h00},
        {1'b1, 3'd1, 8'h00, 8'hA5},
        {1'b1, 3'd2, 8'h00, 8'h3C},
        {1'b1, 3'd3, 8'h00, 8'h77},
        {1'b1, 3'd0, 8'h00, 8'h03},
        {1'b0, 3'd0, 8'h07, 8'h00},
        {1'b1, 3'd0, 8'h00, 8'h03},
        {1'b1, 3'd4, 8'h00, 8'h00}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick(1);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        rd_en = 1'b1; rd_addr = a;
        tick(1);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    initial begin
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        check("R1 mode", {7'd0, charge_dflt_o}, 8'h01);
        check("R1 int", {7'd0, int_n_o}, 8'h01);
        rd(3'd4, r); check("R2 stat after reset", r, 8'h03);
        rd(3'd4, r); check("R7 flag clear on read", r, 8'h01);
        rd(3'd1, r); check("R1 cfgA default", r, 8'h5A);
        rd(3'd0, r); check("R1 ctrl default", r, 8'h01);

        // vector table: R3 entry, readback, R6 kick reads 0, R2 host status
        for (int i = 0; i < 11; i++) begin
            if (VEC[i][19]) begin
                rd(VEC[i][18:16], r);
                check("R3/R6/R2 table", r, VEC[i][7:0]);
            end else begin
                wr(VEC[i][18:16], VEC[i][15:8]);
            end
        end

        // R4/R8 timeout with period 01
        wr(3'd0, 8'h05);
        tick(7); check("R3 still host", {7'd0, charge_dflt_o}, 8'h00);
        tick(1); check("R4 timeout", {7'd0, charge_dflt_o}, 8'h01);
        check("R8 int low", {7'd0, int_n_o}, 8'h00);
        tick(2); check("R8 int last", {7'd0, int_n_o}, 8'h00);
        tick(1); check("R8 int end", {7'd0, int_n_o}, 8'h01);
        rd(3'd1, r); check("R4 cfgA reload", r, 8'h5A);
        rd(3'd3, r); check("R5 keep retained", r, 8'h77);
        rd(3'd0, r); check("R4 ctrl reload", r, 8'h01);
        rd(3'd4, r); check("R7 flag set", r, 8'h03);
        rd(3'd4, r); check("R7 flag cleared", r, 8'h01);

        // R6 kick before timeout
        wr(3'd1, 8'h11);
        tick(5);
        wr(3'd0, 8'h05);
        tick(7); check("R6 held by kick", {7'd0, charge_dflt_o}, 8'h00);
        tick(1); check("R6 expiry after kick", {7'd0, charge_dflt_o}, 8'h01);
        tick(4);

        // R9 disabled, then R8 masked timeout
        wr(3'd0, 8'h00);
        tick(100); check("R9 disabled holds", {7'd0, charge_dflt_o}, 8'h00);
        wr(3'd0, 8'h0D);
        tick(8); check("R8 masked timeout", {7'd0, charge_dflt_o}, 8'h01);
        for (int k = 0; k < 4; k++) begin
            check("R8 masked int", {7'd0, int_n_o}, 8'h01);
            tick(1);
        end
        rd(3'd4, r); check("R8 flag despite mask", r, 8'h03);

        // R6 kick in timeout cycle
        wr(3'd0, 8'h05);
        tick(7);
        wr(3'd0, 8'h05);
        check("R6 kick at expiry", {7'd0, charge_dflt_o}, 8'h00);
        tick(7); check("R6 full period", {7'd0, charge_dflt_o}, 8'h00);
        tick(1); check("R6 then expires", {7'd0, charge_dflt_o}, 8'h01);
        tick(4);

        // R7 read in timeout cycle
        rd(3'd4, r);
        rd(3'd4, r); check("R7 cleared", r, 8'h01);
        wr(3'd0, 8'h05);
        tick(7);
        rd(3'd4, r); check("R7 read at expiry old", r, 8'h00);
        rd(3'd4, r); check("R7 set wins", r, 8'h03);
        tick(3);

        // R4 non-kick write at timeout discarded
        wr(3'd0, 8'h05);
        tick(7);
        wr(3'd2, 8'hEE);
        check("R4 expiry over write", {7'd0, charge_dflt_o}, 8'h01);
        rd(3'd2, r); check("R4 write discarded", r, 8'hC3);
        tick(3);

        // R10 write to status
        wr(3'd4, 8'hFF);
        check("R10 status write enters host", {7'd0, charge_dflt_o}, 8'h00);
        rd(3'd4, r); check("R10 status unchanged", r, 8'h02);
        rd(3'd4, r); check("R10 status after clear", r, 8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule